// File: doc/BRIEF.md
# Non-blocking Miss Fill/Pend Tracker

This block sits beside a data cache and keeps track of read misses that are still waiting for memory, so the core can go on hitting in the cache while line data is fetched. Every miss that names a new line takes a slot in a small fill table. That slot gets exactly one bus fetch, tagged with the slot index. A miss to a line that already has a fetch in flight does not fetch again. It is parked in a separate pend table, linked to the fill slot it is waiting on. Uncached loads always take their own fill slot and are never merged.

When a fill response returns for a slot, the slot is freed. In that same cycle, every pend entry linked to it is retired, with one completion pulse per retired entry. When the tracker cannot take a miss, it raises a stall. A drain input blocks every new miss and reports completion once both tables are empty.

Top module: `miss_fill_tracker`

## Requirements
- R1: After reset both tables are empty. `req_valid` is 0, `miss_result` is 0, `miss_stall` is 0, and `drain_done` follows `drain_req`.
- R2: A cacheable miss whose line address (`miss_addr[31:5]`) matches no live cacheable fill slot is accepted with `miss_result`=1 (new) when a slot is free. It takes the lowest free slot index, and a bus request carrying that index as `req_tag` and the line address as `req_line` follows.
- R3: When all four fill slots are busy, a miss that needs a new slot raises `miss_stall`, reports `miss_result`=0, and leaves both tables unchanged.
- R4: A cacheable miss whose line matches a live cacheable fill slot is accepted with `miss_result`=2 (merged) and issues no bus request. Up to four such misses are held in the pend table.
- R5: A merging miss that finds all four pend entries busy stalls, even when fill slots are free.
- R6: An uncached miss (`miss_nc`=1) always takes a new fill slot, even if its line matches a live slot, and its request carries `req_nc`=1. Cacheable misses never merge onto an uncached slot.
- R7: Bus requests leave in allocation order, at most one per cycle. A request held with `req_ready`=0 keeps `req_valid`, `req_tag` and `req_line` stable.
- R8: A response for tag i pulses `fill_done[i]` in the same cycle. In that cycle `pend_done[j]` pulses for every pend entry j linked to slot i, and the slot is free from the next cycle.
- R9: A cacheable miss that matches slot i in the cycle its response returns reports `miss_result`=3 (served by the returning fill) and allocates nothing.
- R10: While `drain_req` is high every miss stalls. `drain_done` is high only while `drain_req` is high and both tables are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A miss is presented this cycle |
| miss_addr | input | 32 | Byte address of the miss |
| miss_nc | input | 1 | Miss is an uncached load |
| miss_stall | output | 1 | Miss cannot be taken this cycle |
| miss_result | output | 2 | 0 none/stall, 1 new slot, 2 merged, 3 served by returning fill |
| req_valid | output | 1 | Bus fetch request pending |
| req_ready | input | 1 | Bus accepts the request |
| req_tag | output | 2 | Fill slot index of the request |
| req_line | output | 27 | Line address to fetch |
| req_nc | output | 1 | Request is an uncached load |
| resp_valid | input | 1 | Fill response arrives |
| resp_tag | input | 2 | Slot index of the response |
| fill_done | output | 4 | Per-slot completion pulse |
| pend_done | output | 4 | Per-pend-entry completion pulse |
| drain_req | input | 1 | Drain command (level) |
| drain_done | output | 1 | Drain complete |

## Verification
The bench fills all four slots and then presents a fifth distinct line. A tracker that overcounted free slots would overwrite a live entry there instead of stalling. It fills the pend table while a fill slot is free. A design that checked only fill occupancy would take a fifth merge and lose the link.

A miss is timed onto the exact cycle its line's response returns. A wrong tracker would allocate a duplicate fetch or merge onto a slot that is being freed. An uncached slot and a cacheable slot are placed on the same line, which exposes any tracker that merges across the two kinds. During a drain the completion flag is watched through the last response; raising it one cycle early would signal empty while a slot is still live.

// File: rtl/mft_pkg.sv
package mft_pkg;

    localparam int ADDR_W_DEF   = 32;
    localparam int LINE_OFF_DEF = 5;
    localparam int NFILL_DEF    = 4;
    localparam int NPEND_DEF    = 4;

    typedef enum logic [1:0] {
        RES_NONE    = 2'd0,
        RES_NEW     = 2'd1,
        RES_MERGE   = 2'd2,
        RES_HITFILL = 2'd3
    } miss_res_e;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mft_fill_table.sv
module mft_fill_table #(
    parameter int NFILL  = 4,
    parameter int LINE_W = 27,
    parameter int TAG_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_en,
    input  logic [LINE_W-1:0] alloc_line,
    input  logic              alloc_nc,
    input  logic              issue_en,
    input  logic [TAG_W-1:0]  issue_tag,
    input  logic              free_en,
    input  logic [TAG_W-1:0]  free_tag,
    input  logic [LINE_W-1:0] look_line,
    output logic [NFILL-1:0]  match_vec,
    output logic [TAG_W-1:0]  free_slot,
    output logic              full,
    output logic              empty,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line,
    output logic              rd_nc
);

    typedef struct packed {
        logic              valid;
        logic              issued;
        logic              nc;
        logic [LINE_W-1:0] line;
    } fill_ent_t;

    fill_ent_t ents [NFILL];
    logic [NFILL-1:0] busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NFILL; i++) begin
                ents[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NFILL; i++) begin
                if (free_en && free_tag == TAG_W'(i)) begin
                    ents[i].valid  <= 1'b0;
                    ents[i].issued <= 1'b0;
                end
                if (issue_en && issue_tag == TAG_W'(i)) begin
                    ents[i].issued <= 1'b1;
                end
                if (alloc_en && free_slot == TAG_W'(i)) begin
                    ents[i].valid  <= 1'b1;
                    ents[i].issued <= 1'b0;
                    ents[i].nc     <= alloc_nc;
                    ents[i].line   <= alloc_line;
                end
            end
        end
    end

    generate
        for (genvar g = 0; g < NFILL; g++) begin : g_slot
            assign busy[g]      = ents[g].valid;
            assign match_vec[g] = ents[g].valid && !ents[g].nc && (ents[g].line == look_line);
        end
    endgenerate

    always_comb begin
        free_slot = '0;
        for (int i = NFILL - 1; i >= 0; i--) begin
            if (!busy[i]) free_slot = TAG_W'(i);
        end
    end

    assign full    = &busy;
    assign empty   = ~|busy;
    assign rd_line = ents[rd_tag].line;
    assign rd_nc   = ents[rd_tag].nc;

    a_r8_resp_to_live: assert property (@(posedge clk) disable iff (rst)
        free_en |-> (ents[free_tag].valid && ents[free_tag].issued));
    a_r2_alloc_into_free: assert property (@(posedge clk) disable iff (rst)
        alloc_en |-> !ents[free_slot].valid);
    a_r7_issue_once: assert property (@(posedge clk) disable iff (rst)
        issue_en |-> (ents[issue_tag].valid && !ents[issue_tag].issued));

endmodule

// File: rtl/mft_pend_table.sv
module mft_pend_table #(
    parameter int NPEND = 4,
    parameter int TAG_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_en,
    input  logic [TAG_W-1:0] alloc_link,
    input  logic             retire_en,
    input  logic [TAG_W-1:0] retire_link,
    output logic [NPEND-1:0] retire_vec,
    output logic             full,
    output logic             empty
);

    localparam int PIDX_W = mft_pkg::idx_w(NPEND);

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] link;
    } pend_ent_t;

    pend_ent_t        ents [NPEND];
    logic [NPEND-1:0] busy;
    logic [PIDX_W-1:0] free_idx;

    generate
        for (genvar g = 0; g < NPEND; g++) begin : g_pend
            assign busy[g]       = ents[g].valid;
            assign retire_vec[g] = retire_en && ents[g].valid && (ents[g].link == retire_link);
        end
    endgenerate

    always_comb begin
        free_idx = '0;
        for (int i = NPEND - 1; i >= 0; i--) begin
            if (!busy[i]) free_idx = PIDX_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPEND; i++) begin
                ents[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NPEND; i++) begin
                if (retire_vec[i]) ents[i].valid <= 1'b0;
                if (alloc_en && free_idx == PIDX_W'(i)) begin
                    ents[i].valid <= 1'b1;
                    ents[i].link  <= alloc_link;
                end
            end
        end
    end

    assign full  = &busy;
    assign empty = ~|busy;

    a_r5_no_pend_overflow: assert property (@(posedge clk) disable iff (rst)
        alloc_en |-> !full);
    a_r8_retire_gone: assert property (@(posedge clk) disable iff (rst)
        retire_vec[0] |=> !ents[0].valid);

endmodule

// File: rtl/mft_req_queue.sv
module mft_req_queue #(
    parameter int DEPTH = 4,
    parameter int TAG_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_en,
    input  logic [TAG_W-1:0] push_tag,
    input  logic             pop_en,
    output logic             head_valid,
    output logic [TAG_W-1:0] head_tag
);

    localparam int PTR_W = mft_pkg::idx_w(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [TAG_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] cnt;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_en) begin
                slots[wr_ptr] <= push_tag;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop_en) rd_ptr <= bump(rd_ptr);
            case ({push_en, pop_en})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign head_valid = (cnt != '0);
    assign head_tag   = slots[rd_ptr];

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push_en |-> (cnt != CNT_W'(DEPTH)));
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
        pop_en |-> head_valid);

endmodule

// File: rtl/miss_fill_tracker.sv
module miss_fill_tracker
    import mft_pkg::*;
#(
    parameter int ADDR_W   = ADDR_W_DEF,
    parameter int LINE_OFF = LINE_OFF_DEF,
    parameter int NFILL    = NFILL_DEF,
    parameter int NPEND    = NPEND_DEF,
    localparam int LINE_W  = ADDR_W - LINE_OFF,
    localparam int TAG_W   = idx_w(NFILL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic              miss_nc,
    output logic              miss_stall,
    output logic [1:0]        miss_result,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [TAG_W-1:0]  req_tag,
    output logic [LINE_W-1:0] req_line,
    output logic              req_nc,
    input  logic              resp_valid,
    input  logic [TAG_W-1:0]  resp_tag,
    output logic [NFILL-1:0]  fill_done,
    output logic [NPEND-1:0]  pend_done,
    input  logic              drain_req,
    output logic              drain_done
);

    logic [LINE_W-1:0]   miss_line;
    logic [LINE_OFF-1:0] unused_offset;
    logic [NFILL-1:0]    match_vec;
    logic [TAG_W-1:0]    match_tag, free_slot;
    logic                hit, ret_hit;
    logic                fill_full, fill_empty, pend_full, pend_empty;
    logic                alloc_fill, alloc_pend, req_fire;
    miss_res_e           res;

    assign miss_line     = miss_addr[ADDR_W-1:LINE_OFF];
    assign unused_offset = miss_addr[LINE_OFF-1:0];

    always_comb begin
        match_tag = '0;
        for (int i = 0; i < NFILL; i++) begin
            if (match_vec[i]) match_tag = TAG_W'(i);
        end
    end

    assign hit     = |match_vec;
    assign ret_hit = resp_valid && hit && (match_tag == resp_tag);

    always_comb begin
        res        = RES_NONE;
        alloc_fill = 1'b0;
        alloc_pend = 1'b0;
        if (miss_valid && !drain_req) begin
            if (!miss_nc && ret_hit) begin
                res = RES_HITFILL;
            end else if (!miss_nc && hit) begin
                if (!pend_full) begin
                    res        = RES_MERGE;
                    alloc_pend = 1'b1;
                end
            end else if (!fill_full) begin
                res        = RES_NEW;
                alloc_fill = 1'b1;
            end
        end
    end

    assign miss_result = res;
    assign miss_stall  = miss_valid && (res == RES_NONE);
    assign req_fire    = req_valid && req_ready;
    assign fill_done   = resp_valid ? (NFILL'(1) << resp_tag) : '0;
    assign drain_done  = drain_req && fill_empty && pend_empty;

    mft_fill_table #(.NFILL(NFILL), .LINE_W(LINE_W), .TAG_W(TAG_W)) u_fill (
        .clk(clk), .rst(rst),
        .alloc_en(alloc_fill), .alloc_line(miss_line), .alloc_nc(miss_nc),
        .issue_en(req_fire), .issue_tag(req_tag),
        .free_en(resp_valid), .free_tag(resp_tag),
        .look_line(miss_line), .match_vec(match_vec),
        .free_slot(free_slot), .full(fill_full), .empty(fill_empty),
        .rd_tag(req_tag), .rd_line(req_line), .rd_nc(req_nc)
    );

    mft_pend_table #(.NPEND(NPEND), .TAG_W(TAG_W)) u_pend (
        .clk(clk), .rst(rst),
        .alloc_en(alloc_pend), .alloc_link(match_tag),
        .retire_en(resp_valid), .retire_link(resp_tag),
        .retire_vec(pend_done), .full(pend_full), .empty(pend_empty)
    );

    mft_req_queue #(.DEPTH(NFILL), .TAG_W(TAG_W)) u_queue (
        .clk(clk), .rst(rst),
        .push_en(alloc_fill), .push_tag(free_slot),
        .pop_en(req_fire),
        .head_valid(req_valid), .head_tag(req_tag)
    );

    a_r4_match_unique: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_vec));
    a_r7_req_hold: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_tag) && $stable(req_line)));
    a_r8_done_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fill_done));
    a_r8_pend_with_fill: assert property (@(posedge clk) disable iff (rst)
        (|pend_done) |-> (|fill_done));
    a_r10_drain_blocks: assert property (@(posedge clk) disable iff (rst)
        drain_req |-> (miss_result == 2'd0));
    a_r10_done_empty: assert property (@(posedge clk) disable iff (rst)
        drain_done |-> (fill_empty && pend_empty));
    a_r3_new_needs_room: assert property (@(posedge clk) disable iff (rst)
        (miss_result == 2'd1) |-> !fill_full);

endmodule

// File: tb/miss_fill_tracker_bench.sv
module miss_fill_tracker_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        miss_valid, miss_nc, req_ready, resp_valid, drain_req;
    logic [31:0] miss_addr;
    logic [1:0]  resp_tag;
    logic        miss_stall, req_valid, req_nc, drain_done;
    logic [1:0]  miss_result, req_tag;
    logic [26:0] req_line;
    logic [3:0]  fill_done, pend_done;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    miss_fill_tracker u_miss_fill_tracker (
        .clk(clk), .rst(rst),
        .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_nc(miss_nc),
        .miss_stall(miss_stall), .miss_result(miss_result),
        .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag),
        .req_line(req_line), .req_nc(req_nc),
        .resp_valid(resp_valid), .resp_tag(resp_tag),
        .fill_done(fill_done), .pend_done(pend_done),
        .drain_req(drain_req), .drain_done(drain_done)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Drive all inputs after a falling edge, then settle 1 ns before checks.
    task automatic drive(input logic mv, input logic [31:0] a, input logic nc,
                         input logic rv, input logic [1:0] rt, input logic rdy,
                         input logic drn);
        @(negedge clk);
        miss_valid = mv; miss_addr = a; miss_nc = nc;
        resp_valid = rv; resp_tag = rt; req_ready = rdy; drain_req = drn;
        #1;
    endtask

    task automatic idle();
        drive(1'b0, 32'h0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        drive(1'b0, 32'h0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1);
        drive(1'b0, 32'h0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 req_valid", req_valid, 0);
        chk("R1 result", miss_result, 0);
        chk("R1 stall", miss_stall, 0);
        chk("R1 drain_done", drain_done, 1);
        idle();
        chk("R1 drain_done low", drain_done, 0);
    endtask

    task automatic t_alloc();
        drive(1'b1, 32'h1000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R2 new", miss_result, 1);
        drive(1'b1, 32'h2000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R2 new second", miss_result, 1);
        chk("R2 req tag", req_tag, 0);
        chk("R2 req line", req_line, 27'h80);
        idle();
        chk("R7 held valid", req_valid, 1);
        chk("R7 held tag", req_tag, 0);
        drive(1'b0, 32'h0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0);
        chk("R7 first out", req_tag, 0);
        drive(1'b0, 32'h0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0);
        chk("R7 second tag", req_tag, 1);
        chk("R7 second line", req_line, 27'h100);
        idle();
        chk("R7 queue empty", req_valid, 0);
    endtask

    task automatic t_full();
        drive(1'b1, 32'h3000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
        drive(1'b1, 32'h4000, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0);
        chk("R2 tag2 out", req_tag, 2);
        drive(1'b1, 32'h5000, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0);
        chk("R3 stall", miss_stall, 1);
        chk("R3 result", miss_result, 0);
        chk("R2 tag3 out", req_tag, 3);
        drive(1'b1, 32'h1004, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R4 merge", miss_result, 2);
        chk("R4 no request", req_valid, 0);
        drive(1'b1, 32'h1008, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
        drive(1'b1, 32'h100c, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
        drive(1'b1, 32'h101f, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R4 fourth merge", miss_result, 2);
        drive(1'b0, 32'h0, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0);
        chk("R8 fill_done", fill_done, 4'b0010);
        chk("R8 no pend", pend_done, 4'b0000);
        drive(1'b1, 32'h1010, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R5 pend full stall", miss_stall, 1);
        drive(1'b1, 32'h6000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R8 slot reused", miss_result, 1);
        drive(1'b0, 32'h0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0);
        chk("R8 fill_done 0", fill_done, 4'b0001);
        chk("R8 pend all", pend_done, 4'b1111);
        chk("R2 req for slot1", req_tag, 1);
    endtask

    task automatic t_nc();
        drive(1'b1, 32'h6000, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R6 nc new", miss_result, 1);
        drive(1'b0, 32'h0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0);
        chk("R7 order tag1", req_tag, 1);
        chk("R6 cacheable nc bit", req_nc, 0);
        drive(1'b0, 32'h0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0);
        chk("R6 nc tag", req_tag, 0);
        chk("R6 nc flag", req_nc, 1);
        chk("R6 nc line", req_line, 27'h300);
        drive(1'b1, 32'h6010, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R6 merge onto cacheable", miss_result, 2);
        chk("R6 no new req", req_valid, 0);
    endtask

    task automatic t_hitfill();
        drive(1'b1, 32'h3000, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0);
        chk("R9 hit on fill", miss_result, 3);
        chk("R9 fill_done", fill_done, 4'b0100);
        idle();
        chk("R9 no alloc", req_valid, 0);
        drive(1'b1, 32'h3000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R9 later new", miss_result, 1);
        drive(1'b0, 32'h0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0);
        chk("R2 reused tag2", req_tag, 2);
    endtask

    task automatic t_drain();
        drive(1'b0, 32'h0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1);
        chk("R10 not done", drain_done, 0);
        drive(1'b1, 32'h7000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1);
        chk("R10 new blocked", miss_stall, 1);
        drive(1'b1, 32'h4000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1);
        chk("R10 merge blocked", miss_result, 0);
        drive(1'b0, 32'h0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1);
        chk("R10 busy 3 left", drain_done, 0);
        drive(1'b0, 32'h0, 1'b0, 1'b1, 2'd1, 1'b0, 1'b1);
        chk("R8 linked pend", pend_done, 4'b0001);
        drive(1'b0, 32'h0, 1'b0, 1'b1, 2'd2, 1'b0, 1'b1);
        drive(1'b0, 32'h0, 1'b0, 1'b1, 2'd3, 1'b0, 1'b1);
        chk("R10 last resp cycle", drain_done, 0);
        drive(1'b0, 32'h0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1);
        chk("R10 done", drain_done, 1);
        drive(1'b1, 32'h7000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
        chk("R2 after drain", miss_result, 1);
        idle();
        chk("R2 after drain tag", req_tag, 0);
    endtask

    initial begin
        rst = 1'b1;
        miss_valid = 1'b0; miss_addr = '0; miss_nc = 1'b0;
        req_ready = 1'b0; resp_valid = 1'b0; resp_tag = '0; drain_req = 1'b0;
        t_reset();
        t_alloc();
        t_full();
        t_nc();
        t_hitfill();
        t_drain();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule